// File: doc/BRIEF.md
# Transmit Link Phase Sequencer

This block is the transmit-side link-layer controller of a multi-lane 8b/10b converter link. It sits in front of the per-lane encoders. For every octet slot it decides what each lane carries: nothing (idle), code-group synchronization characters, the initial lane alignment sequence, or user data. Its inputs are an active-low synchronization request from the receiving partner, a reference pulse that aligns the local multiframe, and the frame and multiframe sizes.

After reset the sequencer stays idle. It starts only when the partner actually pulls the request line low. It sends 0xBC on every lane for as long as the request is held low. Once the line is released it waits for the next multiframe boundary and then runs a four-multiframe alignment sequence. After that it hands over to user data and marks the end of each multiframe with a control character. If the partner holds the line low for at least one full frame, every lane returns to synchronization characters. Each lane carries one octet per clock.

Top module: `lnk_tx_seq`

## Requirements
- R1: After reset, and for as long as the sequencer stays idle, every lane outputs octet 0x00 with the control flag clear. Reference pulses do not change this.
- R2: In the idle phase, the first clock edge that samples sync_n low moves the sequencer into code-group synchronization. While sync_n stays high, it remains idle.
- R3: During code-group synchronization every lane outputs 0xBC with the control flag set.
- R4: The multiframe is cfg_f × cfg_k octet slots long. The slot index counts from 0 up to cfg_f × cfg_k − 1 and then wraps to 0. The product must be at least 2.
- R5: A clock edge that samples sysref high after it was low sets the slot index of the following cycle to 0, whatever the current position.
- R6: Code-group synchronization ends only in a cycle that holds the last slot of a multiframe while sync_n is high. The next cycle is slot 0 of the alignment sequence.
- R7: The alignment sequence lasts exactly 4 multiframes. Slot 0 carries 0x1C with the flag set, the last slot carries 0x7C with the flag set, and every other slot carries the low 8 bits of the slot index with the flag clear.
- R8: In the user-data phase, lane i outputs tx_data[8i+7:8i] with the flag clear, except in the last slot of a multiframe.
- R9: In the user-data phase, the last slot of every multiframe carries 0x7C with the flag set on all lanes. The user octet for that slot is discarded.
- R10: In the alignment or user-data phase, cfg_f consecutive edges that sample sync_n low return every lane to code-group synchronization. A shorter low run has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Octet clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_f | input | 8 | Octets per frame, at least 1 |
| cfg_k | input | 5 | Frames per multiframe, at least 1 |
| sync_n | input | 1 | Partner synchronization request, active low |
| sysref | input | 1 | Multiframe alignment reference |
| tx_data | input | 32 | User octets, lane i in bits 8i+7:8i |
| lane_octet | output | 32 | Octet sent per lane, lane i in bits 8i+7:8i |
| lane_is_k | output | 4 | Per-lane control-character flag |

## Verification
The phase register and the slot index change on the edge that samples the input. The lane outputs are registered from that state, so a sync_n or sysref event shows at the lanes one edge later than it shows in the state. A user octet applied before an edge appears on its lane right after that edge. The bench drives inputs at the falling edge and updates its model at the rising edge. It compares all lanes at the next falling edge, so each expected value is checked in the exact cycle it is due. Directed runs cover short and long low pulses, realignment in the middle of a multiframe and several frame sizes. Seeded random traffic covers the remaining cases.

// File: rtl/lnk_pkg.sv
package lnk_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_CGS  = 2'd1,
        PH_ILAS = 2'd2,
        PH_DATA = 2'd3
    } phase_e;

    localparam logic [7:0] CH_SYNC   = 8'hBC;
    localparam logic [7:0] CH_MF_BEG = 8'h1C;
    localparam logic [7:0] CH_MF_END = 8'h7C;
endpackage

// File: rtl/lnk_mf_counter.sv
module lnk_mf_counter #(
    parameter int FW = 8,
    parameter int KW = 5,
    localparam int IW = FW + KW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [FW-1:0] cfg_f,
    input  logic [KW-1:0] cfg_k,
    input  logic          sysref,
    output logic [IW-1:0] idx,
    output logic          mf_end
);
    typedef struct packed {
        logic [IW-1:0] idx;
        logic          ref_q;
    } cnt_t;

    cnt_t st_d, st_q;
    logic [IW-1:0] mf_len;
    logic          rise;

    always_comb begin
        mf_len = IW'(cfg_f) * IW'(cfg_k);
        mf_end = (st_q.idx >= mf_len - IW'(1));
        rise   = sysref & ~st_q.ref_q;
        st_d       = st_q;
        st_d.ref_q = sysref;
        if (rise || mf_end) st_d.idx = '0;
        else                st_d.idx = st_q.idx + IW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign idx = st_q.idx;
endmodule

// File: rtl/lnk_resync_filter.sv
module lnk_resync_filter #(
    parameter int FW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sync_n,
    input  logic [FW-1:0] cfg_f,
    output logic          resync
);
    logic [FW-1:0] run_d, run_q;

    always_comb begin
        resync = ~sync_n && (run_q >= cfg_f - FW'(1));
        if (sync_n)          run_d = '0;
        else if (&run_q)     run_d = run_q;
        else                 run_d = run_q + FW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) run_q <= '0;
        else        run_q <= run_d;
    end
endmodule

// File: rtl/lnk_lane_mux.sv
module lnk_lane_mux
    import lnk_pkg::*;
#(
    parameter int LANES = 4,
    parameter int IW    = 13,
    localparam int LW   = LANES * 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  phase_e           ph,
    input  logic [IW-1:0]    idx,
    input  logic             mf_end,
    input  logic [LW-1:0]    tx_data,
    output logic [LW-1:0]    lane_octet,
    output logic [LANES-1:0] lane_is_k
);
    logic [LW-1:0]    oct_d, oct_q;
    logic [LANES-1:0] k_d, k_q;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        always_comb begin
            oct_d[8*i +: 8] = 8'h00;
            k_d[i]          = 1'b0;
            unique case (ph)
                PH_CGS: begin
                    oct_d[8*i +: 8] = CH_SYNC;
                    k_d[i]          = 1'b1;
                end
                PH_ILAS: begin
                    if (idx == '0) begin
                        oct_d[8*i +: 8] = CH_MF_BEG;
                        k_d[i]          = 1'b1;
                    end else if (mf_end) begin
                        oct_d[8*i +: 8] = CH_MF_END;
                        k_d[i]          = 1'b1;
                    end else begin
                        oct_d[8*i +: 8] = idx[7:0];
                    end
                end
                PH_DATA: begin
                    if (mf_end) begin
                        oct_d[8*i +: 8] = CH_MF_END;
                        k_d[i]          = 1'b1;
                    end else begin
                        oct_d[8*i +: 8] = tx_data[8*i +: 8];
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            oct_q <= '0;
            k_q   <= '0;
        end else begin
            oct_q <= oct_d;
            k_q   <= k_d;
        end
    end

    assign lane_octet = oct_q;
    assign lane_is_k  = k_q;
endmodule

// File: rtl/lnk_tx_seq.sv
module lnk_tx_seq
    import lnk_pkg::*;
#(
    parameter int LANES   = 4,
    parameter int FW      = 8,
    parameter int KW      = 5,
    parameter int ILAS_MF = 4,
    localparam int IW     = FW + KW,
    localparam int LW     = LANES * 8,
    localparam int MW     = (ILAS_MF > 1) ? $clog2(ILAS_MF) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [FW-1:0]    cfg_f,
    input  logic [KW-1:0]    cfg_k,
    input  logic             sync_n,
    input  logic             sysref,
    input  logic [LW-1:0]    tx_data,
    output logic [LW-1:0]    lane_octet,
    output logic [LANES-1:0] lane_is_k
);
    typedef struct packed {
        phase_e        ph;
        logic [MW-1:0] mfc;
    } seq_t;

    seq_t          st_d, st_q;
    logic [IW-1:0] idx;
    logic          mf_end;
    logic          resync;
    phase_e        cur_ph;

    lnk_mf_counter #(.FW(FW), .KW(KW)) u_mf (
        .clk(clk), .rst_n(rst_n), .cfg_f(cfg_f), .cfg_k(cfg_k),
        .sysref(sysref), .idx(idx), .mf_end(mf_end)
    );

    lnk_resync_filter #(.FW(FW)) u_rs (
        .clk(clk), .rst_n(rst_n), .sync_n(sync_n), .cfg_f(cfg_f),
        .resync(resync)
    );

    always_comb begin
        st_d = st_q;
        unique case (st_q.ph)
            PH_IDLE: if (!sync_n) st_d.ph = PH_CGS;
            PH_CGS: begin
                if (sync_n && mf_end) begin
                    st_d.ph  = PH_ILAS;
                    st_d.mfc = '0;
                end
            end
            PH_ILAS: begin
                if (resync) begin
                    st_d.ph = PH_CGS;
                end else if (mf_end) begin
                    if (st_q.mfc == MW'(ILAS_MF - 1)) st_d.ph  = PH_DATA;
                    else                              st_d.mfc = st_q.mfc + MW'(1);
                end
            end
            PH_DATA: if (resync) st_d.ph = PH_CGS;
            default: st_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{ph: PH_IDLE, mfc: '0};
        else        st_q <= st_d;
    end

    assign cur_ph = st_q.ph;

    lnk_lane_mux #(.LANES(LANES), .IW(IW)) u_mux (
        .clk(clk), .rst_n(rst_n), .ph(cur_ph), .idx(idx), .mf_end(mf_end),
        .tx_data(tx_data), .lane_octet(lane_octet), .lane_is_k(lane_is_k)
    );
endmodule

// File: rtl/lnk_tx_seq_chk.sv
module lnk_tx_seq_chk
    import lnk_pkg::*;
#(
    parameter int LANES = 4,
    parameter int IW    = 13
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sync_n,
    input logic             sysref,
    input logic [LANES*8-1:0] lane_octet,
    input logic [LANES-1:0] lane_is_k,
    input phase_e           cur_ph,
    input logic [IW-1:0]    idx,
    input logic             mf_end,
    input logic             resync
);
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_ph == PH_IDLE) |=> (lane_is_k == '0 && lane_octet == '0));

    a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_ph == PH_IDLE && sync_n) |=> (cur_ph == PH_IDLE));

    a_r2_idle_start: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_ph == PH_IDLE && !sync_n) |=> (cur_ph == PH_CGS));

    a_r3_sync_chars: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_ph == PH_CGS) |=> (&lane_is_k && lane_octet == {LANES{CH_SYNC}}));

    a_r5_ref_align: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sysref) |=> (idx == '0));

    a_r6_boundary_only: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_ph == PH_CGS && !mf_end) |=> (cur_ph != PH_ILAS));

    a_r9_end_marker: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_ph == PH_DATA && mf_end) |=> (&lane_is_k && lane_octet == {LANES{CH_MF_END}}));

    a_r10_resync: assert property (@(posedge clk) disable iff (!rst_n)
        ((cur_ph == PH_ILAS || cur_ph == PH_DATA) && resync) |=> (cur_ph == PH_CGS));
endmodule

bind lnk_tx_seq lnk_tx_seq_chk #(.LANES(LANES), .IW(IW)) u_chk (
    .clk(clk), .rst_n(rst_n), .sync_n(sync_n), .sysref(sysref),
    .lane_octet(lane_octet), .lane_is_k(lane_is_k), .cur_ph(cur_ph),
    .idx(idx), .mf_end(mf_end), .resync(resync)
);

// File: tb/sim_lnk_tx_seq.sv
module sim_lnk_tx_seq;
    localparam int LANES = 4;
    localparam int LW    = LANES * 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [7:0]    cfg_f = 8'd2;
    logic [4:0]    cfg_k = 5'd4;
    logic          sync_n = 1'b1;
    logic          sysref = 1'b0;
    logic [LW-1:0] tx_data = '0;
    logic [LW-1:0] lane_octet;
    logic [LANES-1:0] lane_is_k;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // independent model state: 0 idle, 1 sync chars, 2 alignment, 3 data
    int m_ph, m_mfc, m_idx, m_low;
    bit m_ref;
    logic [LW-1:0]    e_oct;
    logic [LANES-1:0] e_k;

    always #4 clk = ~clk;

    lnk_tx_seq u0 (
        .clk(clk), .rst_n(rst_n), .cfg_f(cfg_f), .cfg_k(cfg_k),
        .sync_n(sync_n), .sysref(sysref), .tx_data(tx_data),
        .lane_octet(lane_octet), .lane_is_k(lane_is_k)
    );

    initial begin
        #1_000_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not complete");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    function automatic string ph_tag(int ph, bit last);
        case (ph)
            0: return "R1";
            1: return "R3";
            2: return "R7";
            default: return last ? "R9" : "R8";
        endcase
    endfunction

    task automatic model_edge(output string dflt);
        int  len = int'(cfg_f) * int'(cfg_k);
        bit  last = (m_idx >= len - 1);
        bit  rs = !sync_n && (m_low >= int'(cfg_f) - 1);
        dflt = ph_tag(m_ph, last);
        for (int i = 0; i < LANES; i++) begin
            case (m_ph)
                0: begin e_oct[8*i +: 8] = 8'h00; e_k[i] = 1'b0; end
                1: begin e_oct[8*i +: 8] = 8'hBC; e_k[i] = 1'b1; end
                2: begin
                    if (m_idx == 0)  begin e_oct[8*i +: 8] = 8'h1C; e_k[i] = 1'b1; end
                    else if (last)   begin e_oct[8*i +: 8] = 8'h7C; e_k[i] = 1'b1; end
                    else             begin e_oct[8*i +: 8] = 8'(m_idx & 255); e_k[i] = 1'b0; end
                end
                default: begin
                    if (last) begin e_oct[8*i +: 8] = 8'h7C; e_k[i] = 1'b1; end
                    else      begin e_oct[8*i +: 8] = tx_data[8*i +: 8]; e_k[i] = 1'b0; end
                end
            endcase
        end
        case (m_ph)
            0: if (!sync_n) m_ph = 1;
            1: if (sync_n && last) begin m_ph = 2; m_mfc = 0; end
            2: if (rs) m_ph = 1;
               else if (last) begin
                   if (m_mfc == 3) m_ph = 3; else m_mfc++;
               end
            default: if (rs) m_ph = 1;
        endcase
        m_low = sync_n ? 0 : m_low + 1;
        if ((sysref && !m_ref) || last) m_idx = 0; else m_idx++;
        m_ref = sysref;
    endtask

    task automatic tick(string tag);
        string dflt;
        @(posedge clk);
        model_edge(dflt);
        @(negedge clk);
        checks++;
        if (lane_octet !== e_oct || lane_is_k !== e_k) begin
            fails++;
            $display("FAIL %s (%s): got octets=%h k=%b expected octets=%h k=%b",
                     tag == "" ? dflt : tag, dflt, lane_octet, lane_is_k, e_oct, e_k);
        end
    endtask

    task automatic do_reset(int f, int k);
        @(negedge clk);
        rst_n  = 1'b0;
        sync_n = 1'b1;
        sysref = 1'b0;
        cfg_f  = 8'(f);
        cfg_k  = 5'(k);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_ph = 0; m_mfc = 0; m_idx = 0; m_low = 0; m_ref = 0;
        checks++;
        if (lane_octet !== '0 || lane_is_k !== '0) begin
            fails++;
            $display("FAIL R1 reset: got octets=%h k=%b expected octets=0 k=0",
                     lane_octet, lane_is_k);
        end
    endtask

    task automatic run(int n, string tag);
        for (int c = 0; c < n; c++) begin
            tx_data = {$urandom, $urandom} [LW-1:0];
            tick(tag);
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        do_reset(2, 4);
        // R1: idle with sync high and reference pulses
        for (int c = 0; c < 40; c++) begin
            sysref = (c % 13 == 5);
            tick("R1");
        end
        sysref = 1'b0;
        // R2: one low sample starts synchronization characters
        sync_n = 1'b0;
        run(2, "R2");
        run(10, "R3");
        // R6: wait for boundary, then alignment and data
        sync_n = 1'b1;
        run(8, "R6");
        run(4 * 8, "R7");
        run(30, "");
        // R5: realign in mid-multiframe during data
        run(3, "");
        sysref = 1'b1;
        run(1, "R5");
        sysref = 1'b0;
        run(20, "R5");
        // R10: short low run ignored, long low run resyncs
        sync_n = 1'b0;
        run(1, "R10");
        sync_n = 1'b1;
        run(10, "R10");
        sync_n = 1'b0;
        run(6, "R10");
        sync_n = 1'b1;
        run(60, "");
        // R4: several frame sizes
        for (int f = 1; f <= 4; f++) begin
            for (int k = 2; k <= 6; k += 2) begin
                do_reset(f, k);
                sync_n = 1'b0;
                run(3, "R2");
                sync_n = 1'b1;
                run(6 * f * k + 20, "R4");
            end
        end
        // random traffic
        for (int s = 0; s < 4; s++) begin
            do_reset(1 + ($urandom % 5), 2 + ($urandom % 7));
            for (int c = 0; c < 1500; c++) begin
                if ($urandom % 40 == 0) sync_n = ~sync_n;
                else if (!sync_n && $urandom % 4 == 0) sync_n = 1'b1;
                sysref = ($urandom % 97 == 0);
                tx_data = {$urandom, $urandom} [LW-1:0];
                tick("");
            end
            sync_n = 1'b1;
            sysref = 1'b0;
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule